// File: doc/BRIEF.md
# Horizontal Sync Normalizer and Regenerator

This block takes a raw horizontal sync in the pixel clock domain, without knowing whether its active level is high or low. It measures each line period and finds the active level: the level that lasts the shorter time. From then on it produces a clean sync pulse. The output polarity is set by one configuration bit, and the pulse length is a programmable number of pixel clocks.

The regenerated pulse is started by the leading edge of the active input pulse. That edge is delayed through a selectable pipeline, so the output sync keeps a fixed timing relationship with a data path of matching latency. Downstream display logic therefore sees sync, data clock and data line up. Two flags report the detected input polarity and whether that detection is currently trusted.

Top module: `hsync_regen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pol_valid` and `pol_active_high` are 0, and `sync_out` sits at its inactive level: 0 when `out_active_high` is 1, and 1 when it is 0.
- R2: A line runs from one sampled rising edge of `sync_in` to the next. At each line end the block compares the number of high samples with the number of low samples. If the high count is smaller, the candidate is active high. If the low count is smaller, the candidate is active low. If the counts are equal, no decision is made.
- R3: `pol_valid` becomes 1, and `pol_active_high` takes the candidate, only at a line end whose candidate matches the candidate of the line just before it. `pol_valid` returns to 0 at a line end that gives a different candidate or a tie.
- R4: While `pol_valid` is 0, `sync_out` stays at its inactive level.
- R5: `sync_out` is high during a pulse when `out_active_high` is 1, and low during a pulse when it is 0.
- R6: A pulse lasts `pulse_width` clock cycles. A value of 0 gives a 1-cycle pulse.
- R7: The pulse starts `delay_sel`+2 rising clock edges after the edge that first samples the leading edge. This corresponds to a pipeline depth of `delay_sel`+1.
- R8: A new leading edge whose delayed strobe arrives while a pulse is still active restarts the full width count.
- R9: The leading edge is the entry into the active level: a rising input edge for active high and a falling input edge for active low. A leading edge is used only if `pol_valid` is 1 when it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Raw horizontal sync of unknown polarity |
| out_active_high | input | 1 | 1: output pulse high; 0: output pulse low |
| pulse_width | input | WIDTH_W | Output pulse length in clocks (0 means 1) |
| delay_sel | input | $clog2(PIPE_DEPTH) | Alignment pipeline depth minus one |
| sync_out | output | 1 | Regenerated sync |
| pol_active_high | output | 1 | Detected input polarity, 1 for active high |
| pol_valid | output | 1 | Detected polarity is trusted |

## Verification
The bench builds the block with its defaults: an 8-bit width, a 16-stage alignment pipeline and 12-bit line counters. With these settings it can reach every delay tap, a width of 0, and widths of up to 255. Those widths are longer than a line, so back-to-back restarts keep the output pulse permanently active. The line lengths used stay far below counter saturation. The bench drives both input polarities, an input whose polarity flips in the middle of a run, and an input with exactly equal high and low times. These cases exercise the tie path, the path that drops the valid flag, and relocking to the other polarity.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    typedef struct packed {
        logic valid;
        logic active_high;
    } pol_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t find_edges(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic logic pick_edge(input pol_t p, input edge_t e);
        return p.valid & (p.active_high ? e.rise : e.fall);
    endfunction

endpackage

// File: rtl/hsr_polarity.sv
module hsr_polarity
    import hsr_pkg::*;
#(
    parameter int LINE_CNT_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_q,
    input  logic sync_qq,
    output pol_t pol,
    output logic line_end
);
    logic [LINE_CNT_W-1:0] hi_q, lo_q;
    logic have_line_q, have_prev_q, prev_q;
    pol_t pol_q;
    edge_t ed;
    logic tie, cand;

    always_comb begin
        ed   = find_edges(sync_q, sync_qq);
        tie  = (hi_q == lo_q);
        cand = (hi_q < lo_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q        <= '0;
            lo_q        <= '0;
            have_line_q <= 1'b0;
            have_prev_q <= 1'b0;
            prev_q      <= 1'b0;
            pol_q       <= '0;
        end else if (ed.rise) begin
            hi_q        <= LINE_CNT_W'(1);
            lo_q        <= '0;
            have_line_q <= 1'b1;
            if (have_line_q) begin
                if (tie) begin
                    have_prev_q <= 1'b0;
                    pol_q.valid <= 1'b0;
                end else begin
                    if (have_prev_q && (cand == prev_q)) begin
                        pol_q.valid       <= 1'b1;
                        pol_q.active_high <= cand;
                    end else begin
                        pol_q.valid <= 1'b0;
                    end
                    prev_q      <= cand;
                    have_prev_q <= 1'b1;
                end
            end
        end else if (sync_q) begin
            if (hi_q != '1) hi_q <= hi_q + LINE_CNT_W'(1);
        end else begin
            if (lo_q != '1) lo_q <= lo_q + LINE_CNT_W'(1);
        end
    end

    assign pol      = pol_q;
    assign line_end = ed.rise & have_line_q;

endmodule

// File: rtl/hsr_align.sv
module hsr_align #(
    parameter int DEPTH  = 16,
    parameter int DSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lead,
    input  logic [DSEL_W-1:0] sel,
    output logic              tap
);
    logic [DEPTH-1:0] stb_q;

    if (DEPTH == 1) begin : g_single
        always_ff @(posedge clk) begin
            if (rst) stb_q <= '0;
            else     stb_q <= lead;
        end
        assign tap = stb_q[0] | (sel != sel);
    end else begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stb_q <= '0;
            else     stb_q <= {stb_q[DEPTH-2:0], lead};
        end
        assign tap = stb_q[sel];
    end

endmodule

// File: rtl/hsr_pulse.sv
module hsr_pulse #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH_W-1:0] width,
    output logic               active,
    output logic [WIDTH_W-1:0] cnt
);
    logic [WIDTH_W-1:0] cnt_q, load_val;

    always_comb load_val = (width == '0) ? WIDTH_W'(1) : width;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (start)        cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - WIDTH_W'(1);
    end

    assign active = (cnt_q != '0);
    assign cnt    = cnt_q;

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
    import hsr_pkg::*;
#(
    parameter int WIDTH_W    = 8,
    parameter int PIPE_DEPTH = 16,
    parameter int LINE_CNT_W = 12,
    localparam int DSEL_W    = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_in,
    input  logic               out_active_high,
    input  logic [WIDTH_W-1:0] pulse_width,
    input  logic [DSEL_W-1:0]  delay_sel,
    output logic               sync_out,
    output logic               pol_active_high,
    output logic               pol_valid
);
    logic sync_q, sync_qq;
    pol_t pol;
    edge_t ed;
    logic lead, line_end, tap, pulse_on;
    logic [WIDTH_W-1:0] pulse_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 1'b0;
            sync_qq <= 1'b0;
        end else begin
            sync_q  <= sync_in;
            sync_qq <= sync_q;
        end
    end

    hsr_polarity #(.LINE_CNT_W(LINE_CNT_W)) u_pol (
        .clk(clk), .rst(rst), .sync_q(sync_q), .sync_qq(sync_qq),
        .pol(pol), .line_end(line_end)
    );

    always_comb begin
        ed   = find_edges(sync_q, sync_qq);
        lead = pick_edge(pol, ed);
    end

    hsr_align #(.DEPTH(PIPE_DEPTH), .DSEL_W(DSEL_W)) u_align (
        .clk(clk), .rst(rst), .lead(lead), .sel(delay_sel), .tap(tap)
    );

    hsr_pulse #(.WIDTH_W(WIDTH_W)) u_pulse (
        .clk(clk), .rst(rst), .start(tap), .width(pulse_width),
        .active(pulse_on), .cnt(pulse_cnt)
    );

    assign sync_out        = out_active_high ? (pulse_on & pol.valid) : ~(pulse_on & pol.valid);
    assign pol_active_high = pol.active_high;
    assign pol_valid       = pol.valid;

endmodule

// File: rtl/hsync_regen_chk.sv
module hsync_regen_chk #(
    parameter int WIDTH_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               sync_out,
    input logic               out_active_high,
    input logic [WIDTH_W-1:0] pulse_width,
    input logic               pol_valid,
    input logic               line_end,
    input logic               tap,
    input logic [WIDTH_W-1:0] cnt
);
    // R1
    reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !pol_valid);

    // R4
    idle_until_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !pol_valid |-> (sync_out == !out_active_high));

    // R3
    valid_at_line_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pol_valid) |-> $past(line_end));

    // R8
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        tap |=> (cnt == (($past(pulse_width) == '0) ? WIDTH_W'(1) : $past(pulse_width))));

    // R6
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        ((cnt != '0) && !tap) |=> (cnt == $past(cnt) - WIDTH_W'(1)));

endmodule

bind hsync_regen hsync_regen_chk #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk(clk), .rst(rst), .sync_out(sync_out), .out_active_high(out_active_high),
    .pulse_width(pulse_width), .pol_valid(pol_valid), .line_end(line_end),
    .tap(tap), .cnt(pulse_cnt)
);

// File: tb/tb_hsync_regen.sv
module tb_hsync_regen;
    localparam int CLK_PERIOD = 10;
    localparam int HIST = 32768;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0;
    logic out_active_high = 1'b1;
    logic [7:0] pulse_width = 8'd1;
    logic [3:0] delay_sel = 4'd0;
    logic sync_out, pol_active_high, pol_valid;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsync_regen dut (
        .clk(clk), .rst(rst), .sync_in(sync_in), .out_active_high(out_active_high),
        .pulse_width(pulse_width), .delay_sel(delay_sel), .sync_out(sync_out),
        .pol_active_high(pol_active_high), .pol_valid(pol_valid)
    );

    // reference model state
    int n;
    bit s_prev, have_line, have_prev, prev_c, m_valid, m_pol;
    int hi, lo;
    bit lead_h[HIST];
    bit val_h[HIST];
    bit pol_h[HIST];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at sample %0d: actual %0d expected %0d", tag, n, act, exp);
        end
    endtask

    function automatic int eff_w();
        return (pulse_width == 0) ? 1 : int'(pulse_width);
    endfunction

    task automatic model_step(input bit s);
        bit rise, fall, cand;
        rise = s & !s_prev;
        fall = !s & s_prev;
        lead_h[n] = m_valid && (m_pol ? rise : fall);   // R9
        if (rise) begin
            if (have_line) begin
                if (hi == lo) begin                      // R2 tie
                    have_prev = 0;
                    m_valid = 0;
                end else begin
                    cand = (hi < lo);
                    if (have_prev && cand == prev_c) begin   // R3
                        m_valid = 1;
                        m_pol = cand;
                    end else m_valid = 0;
                    prev_c = cand;
                    have_prev = 1;
                end
            end
            hi = 1; lo = 0; have_line = 1;
        end else if (s) hi++;
        else lo++;
        val_h[n] = m_valid;
        pol_h[n] = m_pol;
        s_prev = s;
    endtask

    task automatic check_now();
        bit ev, ep, act, lvl, eo;
        int d, w;
        d = int'(delay_sel);
        w = eff_w();
        ev = (n >= 1) ? val_h[n-1] : 0;
        ep = (n >= 1) ? pol_h[n-1] : 0;
        act = 0;
        for (int e = n - d - 1 - w; e <= n - d - 2; e++)
            if (e >= 0 && lead_h[e]) act = 1;
        lvl = act & ev;
        eo = out_active_high ? lvl : !lvl;
        // R4 R5 R6 R7 R8 R9: output level each cycle
        chk(sync_out == eo, "R4/R5/R6/R7/R8/R9 sync_out", int'(sync_out), int'(eo));
        // R2 R3: flags
        chk(pol_valid == ev, "R3 pol_valid", int'(pol_valid), int'(ev));
        chk(pol_active_high == ep, "R2 pol_active_high", int'(pol_active_high), int'(ep));
    endtask

    task automatic tick(input bit s);
        sync_in = s;
        model_step(s);
        @(posedge clk);
        @(negedge clk);
        check_now();
        n++;
    endtask

    task automatic start_phase(input bit op, input int w, input int d);
        out_active_high = op;
        pulse_width = 8'(w);
        delay_sel = 4'(d);
        rst = 1'b1;
        sync_in = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(pol_valid == 0, "R1 pol_valid in reset", int'(pol_valid), 0);
        chk(sync_out == !op, "R1 sync_out in reset", int'(sync_out), int'(!op));
        rst = 1'b0;
        n = 0; s_prev = 0; have_line = 0; have_prev = 0; prev_c = 0;
        m_valid = 0; m_pol = 0; hi = 0; lo = 0;
    endtask

    task automatic gen_line(input int len, input int pw, input bit act_high);
        for (int i = 0; i < len; i++) tick((i < pw) ? act_high : !act_high);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);

        // directed: active-high input, short delay
        start_phase(1, 5, 0);
        for (int l = 0; l < 10; l++) gen_line(100, 8, 1);
        chk(pol_valid == 1 && pol_active_high == 1, "R2 active-high lock",
            int'({pol_valid, pol_active_high}), 3);

        // directed: active-low input, deepest pipeline, width 0
        start_phase(0, 0, 15);
        for (int l = 0; l < 10; l++) gen_line(80, 6, 0);
        chk(pol_valid == 1 && pol_active_high == 0, "R2 active-low lock",
            int'({pol_valid, pol_active_high}), 2);

        // directed: width longer than line, continual restart
        start_phase(1, 255, 3);
        for (int l = 0; l < 8; l++) gen_line(50, 4, 1);
        chk(sync_out == 1, "R8 continual restart", int'(sync_out), 1);

        // directed: equal high and low time never validates
        start_phase(1, 4, 2);
        for (int l = 0; l < 10; l++) gen_line(40, 20, 1);
        chk(pol_valid == 0, "R3 tie never valid", int'(pol_valid), 0);

        // directed: polarity flips mid run
        start_phase(1, 10, 7);
        for (int l = 0; l < 8; l++) gen_line(90, 9, 1);
        for (int l = 0; l < 8; l++) gen_line(90, 9, 0);
        chk(pol_valid == 1 && pol_active_high == 0, "R3 relock after flip",
            int'({pol_valid, pol_active_high}), 2);

        // constrained random phases
        for (int k = 0; k < 6; k++) begin
            bit ip;
            ip = 1'($urandom % 2);
            start_phase(1'($urandom % 2), int'($urandom % 256), int'($urandom % 16));
            for (int l = 0; l < 14; l++)
                gen_line(60 + int'($urandom % 60), 3 + int'($urandom % 12), ip);
            chk(pol_valid == 1 && pol_active_high == ip, "R2 random lock",
                int'({pol_valid, pol_active_high}), int'({1'b1, ip}));
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule